// File: doc/BRIEF.md
# Split Double-Width Event Counter

This block counts events in a register twice the core data width. The count is stored as two separately addressable halves of `HALF_W` bits each. The low half carries the least significant bits and the high half carries the most significant bits. A one-cycle `tick` strobe advances the combined value by one. When the low half rolls over, the carry moves into the high half on the same clock edge. When the full value rolls over, it returns to zero.

Each half has its own read port and its own write port for instructions. A write replaces only the half it targets. The read ports are driven straight from the half registers, so a read always returns the value that was stored before the current cycle's increment.

The build parameter `HAS_UPPER` removes the high half completely. In that case the counter is `HALF_W` bits wide, the high read port returns zero, and writes to the high half have no effect. Address decoding and privilege checks belong to the surrounding CSR unit.

Top module: `wide_event_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, both halves become zero. Both read ports show zero from the following cycle.
- R2: A cycle with `tick` high and no write to either half adds exactly one to the combined value {high, low}. A cycle with no tick and no writes leaves both halves unchanged.
- R3: When `tick` is high and the low half is all ones, with no writes, the low half becomes zero and the high half increases by one on the same edge.
- R4: When both halves are all ones and `tick` is high with no writes, both halves become zero on the next edge.
- R5: When `lo_wr_en` is high, the low half takes `lo_wr_data` on the next edge even if `tick` is high. That cycle's increment is dropped, so it produces no carry into the high half.
- R6: When `hi_wr_en` is high, the high half takes `hi_wr_data` on the next edge even if a carry arrives in that cycle. The low half still follows its own tick and write inputs.
- R7: The read ports show the registered halves. In the cycle where `tick` is high, `lo_rd_data` still shows the value from before the increment.
- R8: With `HAS_UPPER` = 0, `hi_rd_data` is always zero and `hi_wr_en` has no effect. The low half wraps from all ones to zero and follows R1, R2, R5 and R7 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Increment strobe, one count per cycle it is high |
| lo_wr_en | input | 1 | Instruction write enable for the low half |
| lo_wr_data | input | HALF_W | Write data for the low half |
| hi_wr_en | input | 1 | Instruction write enable for the high half |
| hi_wr_data | input | HALF_W | Write data for the high half |
| lo_rd_data | output | HALF_W | Low half of the count, bits [HALF_W-1:0] |
| hi_rd_data | output | HALF_W | High half of the count, bits [2*HALF_W-1:HALF_W]; zero when HAS_UPPER = 0 |

## Verification
Every cycle, the assertions check the following:
- the single-step advance of the low half;
- carry propagation into the high half;
- the priority of each half's write over its increment;
- that idle halves hold their value;
- that the high read port is tied to zero when the high half is removed.

Other behaviours are shown only by the bench scenarios, which run an instance with the high half and an instance without it side by side:
- the combined rollover of both halves to zero;
- a low write cancelling the carry it would otherwise have caused;
- a reset clearing the halves after the count has been loaded;
- a read in the tick cycle returning the pre-increment value.

// File: rtl/wec_pkg.sv
package wec_pkg;

  // Selects where a half register takes its next value from
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_INC  = 2'd1,
    SRC_LOAD = 2'd2
  } half_src_e;

endpackage

// File: rtl/wec_src_sel.sv
module wec_src_sel
  import wec_pkg::*;
(
  input  logic      wr_en,
  input  logic      inc_en,
  output half_src_e src
);

  // An instruction write takes priority over the increment
  always_comb begin
    if (wr_en)       src = SRC_LOAD;
    else if (inc_en) src = SRC_INC;
    else             src = SRC_HOLD;
  end

endmodule

// File: rtl/wec_half.sv
module wec_half
  import wec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         inc_en,
  output logic [W-1:0] q,
  output logic         carry_out
);

  localparam logic [W-1:0] ONE = W'(1);

  half_src_e   src;
  logic [W-1:0] q_r;

  wec_src_sel u_sel (
    .wr_en  (wr_en),
    .inc_en (inc_en),
    .src    (src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0;
    end else begin
      case (src)
        SRC_LOAD: q_r <= wr_data;
        SRC_INC:  q_r <= q_r + ONE;
        default:  q_r <= q_r;
      endcase
    end
  end

  // Carry only when an increment actually happens on an all-ones value
  assign carry_out = (src == SRC_INC) && (&q_r);
  assign q         = q_r;

endmodule

// File: rtl/wide_event_counter.sv
module wide_event_counter #(
  parameter int HALF_W    = 32,
  parameter bit HAS_UPPER = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              lo_wr_en,
  input  logic [HALF_W-1:0] lo_wr_data,
  input  logic              hi_wr_en,
  input  logic [HALF_W-1:0] hi_wr_data,
  output logic [HALF_W-1:0] lo_rd_data,
  output logic [HALF_W-1:0] hi_rd_data
);

  logic lo_carry;

  wec_half #(.W(HALF_W)) u_lo (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (lo_wr_en),
    .wr_data   (lo_wr_data),
    .inc_en    (tick),
    .q         (lo_rd_data),
    .carry_out (lo_carry)
  );

  generate
    if (HAS_UPPER) begin : g_upper
      logic hi_carry_unused;
      wec_half #(.W(HALF_W)) u_hi (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (hi_wr_en),
        .wr_data   (hi_wr_data),
        .inc_en    (lo_carry),
        .q         (hi_rd_data),
        .carry_out (hi_carry_unused)
      );
    end else begin : g_no_upper
      logic hi_inputs_unused;
      assign hi_inputs_unused = ^{hi_wr_en, hi_wr_data, lo_carry};
      assign hi_rd_data       = '0;
    end
  endgenerate

endmodule

// File: rtl/wec_checker.sv
module wec_checker #(
  parameter int HALF_W    = 32,
  parameter bit HAS_UPPER = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              lo_wr_en,
  input logic [HALF_W-1:0] lo_wr_data,
  input logic              hi_wr_en,
  input logic [HALF_W-1:0] hi_wr_data,
  input logic [HALF_W-1:0] lo_rd_data,
  input logic [HALF_W-1:0] hi_rd_data
);

  localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

  AST_LO_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !lo_wr_en) |=> (lo_rd_data == $past(lo_rd_data) + ONE)); // R2

  AST_LO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !lo_wr_en) |=> $stable(lo_rd_data)); // R2

  AST_LO_LOAD: assert property (@(posedge clk) disable iff (rst)
    lo_wr_en |=> (lo_rd_data == $past(lo_wr_data))); // R5

  AST_HI_CARRY: assert property (@(posedge clk) disable iff (rst)
    (HAS_UPPER && tick && !lo_wr_en && !hi_wr_en && (&lo_rd_data))
      |=> (hi_rd_data == $past(hi_rd_data) + ONE)); // R3

  AST_HI_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!hi_wr_en && !(tick && !lo_wr_en && (&lo_rd_data)))
      |=> $stable(hi_rd_data)); // R5

  AST_HI_LOAD: assert property (@(posedge clk) disable iff (rst)
    (HAS_UPPER && hi_wr_en) |=> (hi_rd_data == $past(hi_wr_data))); // R6

  AST_NO_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!HAS_UPPER) |-> (hi_rd_data == '0)); // R8

endmodule

bind wide_event_counter wec_checker #(
  .HALF_W    (HALF_W),
  .HAS_UPPER (HAS_UPPER)
) u_wec_checker (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .lo_wr_en   (lo_wr_en),
  .lo_wr_data (lo_wr_data),
  .hi_wr_en   (hi_wr_en),
  .hi_wr_data (hi_wr_data),
  .lo_rd_data (lo_rd_data),
  .hi_rd_data (hi_rd_data)
);

// File: tb/tb_wide_event_counter.sv
`timescale 1ns/1ps
module tb_wide_event_counter;

  localparam int W = 8;
  localparam logic [W-1:0] MAXV = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic lo_wr_en = 1'b0;
  logic hi_wr_en = 1'b0;
  logic [W-1:0] lo_wr_data = '0;
  logic [W-1:0] hi_wr_data = '0;
  logic [W-1:0] lo_rd, hi_rd, lo_rd2, hi_rd2;

  always #10 clk = ~clk;  // 50 MHz

  wide_event_counter #(.HALF_W(W), .HAS_UPPER(1'b1)) dut (
    .clk(clk), .rst(rst), .tick(tick),
    .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data),
    .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data),
    .lo_rd_data(lo_rd), .hi_rd_data(hi_rd)
  );

  wide_event_counter #(.HALF_W(W), .HAS_UPPER(1'b0)) dut_nohi (
    .clk(clk), .rst(rst), .tick(tick),
    .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data),
    .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data),
    .lo_rd_data(lo_rd2), .hi_rd_data(hi_rd2)
  );

  typedef struct {
    string        req;
    logic [W-1:0] lo;
    logic [W-1:0] hi;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [W-1:0] mdl_lo = '0;
  logic [W-1:0] mdl_hi = '0;

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected result
  task automatic step(input logic t, input logic lwe, input logic [W-1:0] lwd,
                      input logic hwe, input logic [W-1:0] hwd, input string req);
    logic carry;
    exp_t e;
    @(negedge clk);
    tick = t; lo_wr_en = lwe; lo_wr_data = lwd;
    hi_wr_en = hwe; hi_wr_data = hwd;
    #1;
    chk("R7", "lo read in stimulus cycle", lo_rd, mdl_lo);
    carry = t && !lwe && (mdl_lo == MAXV);
    @(posedge clk);
    mdl_lo = lwe ? lwd : (t ? mdl_lo + W'(1) : mdl_lo);
    mdl_hi = hwe ? hwd : (carry ? mdl_hi + W'(1) : mdl_hi);
    e.req = req; e.lo = mdl_lo; e.hi = mdl_hi;
    exp_q.push_back(e);
  endtask

  // Monitor: compares outputs one half cycle after the producing edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.req, "lo", lo_rd, e.lo);
      chk(e.req, "hi", hi_rd, e.hi);
      chk(e.req, "lo without high half", lo_rd2, e.lo);
      chk("R8", "hi without high half", hi_rd2, '0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "lo after reset", lo_rd, '0);
    chk("R1", "hi after reset", hi_rd, '0);
    rst = 1'b0;

    // R2: plain counting and idle hold
    step(1, 0, '0, 0, '0, "R2");
    step(1, 0, '0, 0, '0, "R2");
    step(1, 0, '0, 0, '0, "R2");
    step(0, 0, '0, 0, '0, "R2");
    // R5: load low half, then R3 carry into high half
    step(0, 1, 8'hFE, 0, '0, "R5");
    step(1, 0, '0, 0, '0, "R2");
    step(1, 0, '0, 0, '0, "R3");
    // R6: high write alone, low untouched; R8 ignored without high half
    step(0, 0, '0, 1, 8'h5A, "R6");
    // R4: full wrap of both halves
    step(0, 1, MAXV, 1, MAXV, "R5");
    step(1, 0, '0, 0, '0, "R4");
    // R5: low write with tick at all ones cancels the carry
    step(0, 1, MAXV, 0, '0, "R5");
    step(1, 1, 8'h10, 0, '0, "R5");
    // R6: high write wins over an arriving carry
    step(0, 1, MAXV, 1, 8'h20, "R6");
    step(1, 0, '0, 1, 8'h77, "R6");
    step(0, 0, '0, 0, '0, "R2");

    // R1: a reset after activity clears both halves
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mdl_lo = '0; mdl_hi = '0;
    chk("R1", "lo after mid-run reset", lo_rd, '0);
    chk("R1", "hi after mid-run reset", hi_rd, '0);
    chk("R1", "lo without high half after reset", lo_rd2, '0);
    step(1, 0, '0, 0, '0, "R2");
    step(0, 0, '0, 0, '0, "R2");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule